// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Cycle Controller

This block is a synchronous controller that runs read and write cycles on an external asynchronous static RAM. The default size is 2048 words of 8 bits. It drives active-low chip enable, output enable and write enable strobes. It also drives an 11-bit address and a split data bus: an output value, an output enable and an input. The pad cell outside the block turns the split bus into a bidirectional one. When the output enable is low, the controller's side of the bus is high impedance.

On the host side, a request is held high together with a read/write flag, an address and write data until the controller returns a single-clock acknowledge. On a read, the acknowledge comes with the captured read data. Every delay is counted in clock cycles, and each one is set by a parameter:

- the address setup before the strobes fall,
- the read access window, derived from the memory speed grade in nanoseconds and the clock period in picoseconds,
- the write pulse width,
- the write-enable recovery gap,
- the power-fail lockout length.

A power-fail input treats the memory as write protected. It cuts a write in progress short, releases the data bus and answers that write with an error flag. It then refuses new requests until power has been good for a set number of clocks.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high (inactive), the data bus output enable is low and the acknowledge and error outputs are low. The acknowledge is never high for two clocks in a row.
- R2: A read lowers chip enable and output enable on the same clock edge, with write enable high. It holds them low for ACC_CYC = ceil(GRADE_NS*1000/CLK_PS) clock cycles. It then captures the bus into rdata_o and raises both strobes on the edge that pulses the acknowledge. The captured data matches the stored byte at every address, from 0 to 2047.
- R3: The address reaches the memory at least SU_CYC cycles before chip enable falls. It stays unchanged while chip enable is low. Write enable is low only while chip enable is low.
- R4: A write lowers chip enable and write enable on the same edge and holds write enable low for WP_CYC cycles. Write enable then rises while chip enable is still low, on the edge that pulses the acknowledge. Chip enable rises one clock later. The byte stored is wdata_i.
- R5: Output enable stays high at every clock in which write enable is low.
- R6: After write enable rises at the end of a write, it stays high for at least REC_CYC+1 cycles before chip enable falls for the next cycle of any kind.
- R7: The data bus is driven only while chip enable is low during a write. It is driven for exactly WP_CYC+1 cycles per completed write: the write pulse plus one hold clock after write enable rises. It is never driven while output enable is low.
- R8: If power-fail is high at a clock edge during an uncompleted write, that edge raises write enable and chip enable, releases the data bus and pulses the acknowledge with err_o high. The addressed byte keeps its old value.
- R9: While power-fail is high, no request is accepted, write enable stays high and the data bus is released. After power-fail falls, no request is accepted for PF_HOLD clock cycles.
- R10: err_o is high only together with the acknowledge. A completed read or write acknowledges with err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail_i | input | 1 | Power-fail (write protect) indication, synchronous to clk |
| req_i | input | 1 | Host request, held until acknowledge |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 11 | Host byte address |
| wdata_i | input | 8 | Host write data |
| ack_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Write aborted by power-fail, valid with ack_o |
| rdata_o | output | 8 | Captured read data, held until the next read |
| mem_addr_o | output | 11 | Memory address |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o, 0 = high impedance |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The hardest situation to reach is a power failure in the middle of a write pulse. It needs power-fail to rise exactly while write enable is low. The stimulus starts a write, watches the strobe on each falling clock edge, and raises power-fail as soon as write enable is seen low. It then checks the abort edge, keeps power-fail high while a read request waits, and counts the idle cycles after power-fail drops. The bench memory model returns a garbage byte until output enable has been low for the full access window, so a read sampled too early shows up as wrong data.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_ACCESS  = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RECOVER = 3'd4
  } cyc_state_t;

  // Whole cycles needed to cover a time in ns at a clock period in ps.
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_pf_lockout.sv
module sram_pf_lockout #(
  parameter int PF_HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pf,
  output logic locked
);
  localparam int LW = $clog2(PF_HOLD + 1);
  localparam logic [LW-1:0] HOLD_V = LW'(PF_HOLD);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (pf) begin
      cnt <= HOLD_V;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign locked = pf | (cnt != '0);
endmodule

// File: rtl/sram_cyc_fsm.sv
module sram_cyc_fsm
  import sram_cyc_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int SU_CYC  = 1,
  parameter int ACC_CYC = 20,
  parameter int WP_CYC  = 3,
  parameter int REC_CYC = 2,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          pf,
  input  logic          locked,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          ack,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_i
);
  localparam logic [CW-1:0] SU_V  = CW'(SU_CYC - 1);
  localparam logic [CW-1:0] ACC_V = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] WP_V  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_V = CW'(REC_CYC - 1);

  cyc_state_t    state;
  logic          wr_q;
  logic [DW-1:0] wd_q;

  // Timer reload decisions, aligned with the state changes below.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (req && !locked) begin
          tmr_load = 1'b1;
          tmr_val  = SU_V;
        end
      end
      ST_SETUP: begin
        if (wr_q && pf) begin
          tmr_load = 1'b1;
          tmr_val  = REC_V;
        end else if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = wr_q ? WP_V : ACC_V;
        end
      end
      ST_ACCESS: begin
        if (wr_q && pf) begin
          tmr_load = 1'b1;
          tmr_val  = REC_V;
        end
      end
      ST_HOLD: begin
        tmr_load = 1'b1;
        tmr_val  = REC_V;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      ack      <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
      mem_addr <= '0;
      ce_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      dq_o     <= '0;
      dq_oe    <= 1'b0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req && !locked) begin
            mem_addr <= addr;
            wr_q     <= wr;
            wd_q     <= wdata;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (wr_q && pf) begin
            ack   <= 1'b1;
            err   <= 1'b1;
            state <= ST_RECOVER;
          end else if (tmr_zero) begin
            ce_n <= 1'b0;
            if (wr_q) begin
              we_n  <= 1'b0;
              dq_o  <= wd_q;
              dq_oe <= 1'b1;
            end else begin
              oe_n <= 1'b0;
            end
            state <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (wr_q) begin
            if (pf) begin
              we_n  <= 1'b1;
              ce_n  <= 1'b1;
              dq_oe <= 1'b0;
              ack   <= 1'b1;
              err   <= 1'b1;
              state <= ST_RECOVER;
            end else if (tmr_zero) begin
              we_n  <= 1'b1;
              ack   <= 1'b1;
              state <= ST_HOLD;
            end
          end else if (tmr_zero) begin
            rdata <= dq_i;
            ack   <= 1'b1;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          ce_n  <= 1'b1;
          dq_oe <= 1'b0;
          state <= ST_RECOVER;
        end
        ST_RECOVER: begin
          if (tmr_zero) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_cyc_ctrl.sv
module sram_cyc_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int AW       = 11,
  parameter int DW       = 8,
  parameter int CLK_PS   = 5000,
  parameter int GRADE_NS = 100,
  parameter int SU_CYC   = 1,
  parameter int WP_CYC   = 3,
  parameter int REC_CYC  = 2,
  parameter int PF_HOLD  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_fail_i,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_n_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int ACC_CYC = int'(ns_to_cycles(GRADE_NS, CLK_PS));
  localparam int CMAX    = int'(max3(ACC_CYC, WP_CYC, max3(SU_CYC, REC_CYC, 1)));
  localparam int CW      = $clog2(CMAX + 1);

  logic          locked;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  sram_pf_lockout #(.PF_HOLD(PF_HOLD)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .pf     (pwr_fail_i),
    .locked (locked)
  );

  sram_cyc_timer #(.CW(CW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  sram_cyc_fsm #(
    .AW(AW), .DW(DW), .SU_CYC(SU_CYC), .ACC_CYC(ACC_CYC),
    .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .CW(CW)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req_i),
    .wr       (wr_i),
    .addr     (addr_i),
    .wdata    (wdata_i),
    .pf       (pwr_fail_i),
    .locked   (locked),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .ack      (ack_o),
    .err      (err_o),
    .rdata    (rdata_o),
    .mem_addr (mem_addr_o),
    .ce_n     (mem_ce_n_o),
    .oe_n     (mem_oe_n_o),
    .we_n     (mem_we_n_o),
    .dq_o     (mem_dq_o),
    .dq_oe    (mem_dq_oe_o),
    .dq_i     (mem_dq_i)
  );
endmodule

// File: rtl/sram_cyc_chk.sv
module sram_cyc_chk #(
  parameter int AW      = 11,
  parameter int REC_CYC = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          pf,
  input logic          ack,
  input logic          err,
  input logic [AW-1:0] addr,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          dq_oe
);
  localparam int SAT = REC_CYC + 1;
  localparam int HW  = $clog2(SAT + 1);
  localparam logic [HW-1:0] SAT_V = HW'(SAT);

  logic [HW-1:0] we_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_hi <= SAT_V;
    end else if (!we_n) begin
      we_hi <= '0;
    end else if (we_hi < SAT_V) begin
      we_hi <= we_hi + 1'b1;
    end
  end

  p_ack_single_r1: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));

  p_we_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n);

  p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);

  p_recovery_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ce_n) |-> (we_hi >= SAT_V));

  p_dq_needs_ce_r7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !ce_n);

  p_dq_off_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !dq_oe);

  p_pf_protect_r9: assert property (@(posedge clk) disable iff (rst)
    $past(pf) |-> (we_n && !dq_oe));

  p_err_with_ack_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> ack);
endmodule

bind sram_cyc_ctrl sram_cyc_chk #(.AW(AW), .REC_CYC(REC_CYC)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .pf    (pwr_fail_i),
  .ack   (ack_o),
  .err   (err_o),
  .addr  (mem_addr_o),
  .ce_n  (mem_ce_n_o),
  .oe_n  (mem_oe_n_o),
  .we_n  (mem_we_n_o),
  .dq_oe (mem_dq_oe_o)
);

// File: tb/sram_cyc_ctrl_tb.sv
module sram_cyc_ctrl_tb_top;
  localparam int AW = 11, DW = 8;
  localparam int CLK_PS = 5000, GRADE_NS = 100;
  localparam int SU = 1, WP = 3, REC = 3, PFH = 8;
  localparam int ACC = (GRADE_NS * 1000 + CLK_PS - 1) / CLK_PS; // 20

  logic clk = 1'b0, rst = 1'b1, pf = 1'b0, req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ack, err;
  logic [DW-1:0] rdata;
  logic [AW-1:0] m_addr;
  logic ce_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] dq_o, dq_i;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int oe_run = 0;
  logic prev_we = 1'b1;

  always #2.5ns clk = ~clk;

  sram_cyc_ctrl #(
    .AW(AW), .DW(DW), .CLK_PS(CLK_PS), .GRADE_NS(GRADE_NS),
    .SU_CYC(SU), .WP_CYC(WP), .REC_CYC(REC), .PF_HOLD(PFH)
  ) dut_i (
    .clk(clk), .rst(rst), .pwr_fail_i(pf), .req_i(req), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .err_o(err),
    .rdata_o(rdata), .mem_addr_o(m_addr), .mem_ce_n_o(ce_n),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_dq_o(dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // Memory model: data valid only after the full access window.
  assign dq_i = (oe_run >= ACC) ? mem[m_addr] : 8'hEE;

  always @(negedge clk) begin
    if (!ce_n && !oe_n) oe_run = oe_run + 1;
    else oe_run = 0;
    if (!prev_we && we_n && !ce_n && dq_oe && !pf) mem[m_addr] = dq_o;
    prev_we = we_n;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Run one host operation; counts strobe cycles seen on falling edges.
  task automatic host_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output int oe_c, output int we_c,
                         output int dq_c, output bit e);
    int n = 0;
    oe_c = 0; we_c = 0; dq_c = 0;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    do begin
      @(negedge clk);
      n++;
      if (!oe_n) oe_c++;
      if (!we_n) we_c++;
      if (dq_oe) dq_c++;
    end while (!ack && n < 400);
    req = 1'b0;
    rd = rdata; e = err;
    if (n >= 400) chk(0, "host_op timeout", n, 0);
  endtask

  task automatic t_reset;
    chk(ce_n && oe_n && we_n, "R1 strobes idle after reset", {ce_n, oe_n, we_n}, 7);
    chk(!dq_oe && !ack && !err, "R1 bus and ack idle after reset", {dq_oe, ack, err}, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] rd; int oc, wc, dc; bit e;
    host_op(1'b1, a, d, rd, oc, wc, dc, e);
    chk(wc == WP, "R4 write pulse width", wc, WP);
    chk(oc == 0, "R5 OE high during write", oc, 0);
    chk(dc == WP + 1, "R7 drive window", dc, WP + 1);
    chk(we_n && !ce_n && dq_oe, "R4 WE rises before CE with hold", {we_n, ce_n, dq_oe}, 5);
    chk(!e, "R10 no error on good write", e, 0);
    @(negedge clk);
    chk(ce_n && !dq_oe && !ack, "R7 bus released after hold", {ce_n, dq_oe, ack}, 4);
    chk(mem[a] == d, "R4 stored byte", mem[a], d);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] rd; int oc, wc, dc; bit e;
    host_op(1'b0, a, 8'h00, rd, oc, wc, dc, e);
    chk(oc == ACC, "R2 access window", oc, ACC);
    chk(rd == exp, "R2 read data", rd, exp);
    chk(wc == 0 && dc == 0, "R2 no write strobe on read", wc + dc, 0);
    chk(ce_n && oe_n && !e, "R2 strobes released at ack", {ce_n, oe_n, e}, 6);
    @(negedge clk);
    chk(!ack, "R1 ack one clock", ack, 0);
  endtask

  // Two back-to-back writes: count WE-high cycles between them.
  task automatic t_recovery;
    logic [DW-1:0] rd; int oc, wc, dc; bit e; int gap = 0, n = 0;
    host_op(1'b1, 11'h155, 8'h3C, rd, oc, wc, dc, e);
    req = 1'b1; wr = 1'b1; addr = 11'h2AA; wdata = 8'hC3;
    while (ce_n == 1'b0 && n < 50) begin @(negedge clk); n++; end
    while (ce_n == 1'b1 && n < 100) begin @(negedge clk); gap++; n++; end
    // gap counts WE-high cycles with CE high; plus the hold clock.
    chk(gap + 1 >= REC + 1, "R6 WE recovery gap", gap + 1, REC + 1);
    while (!ack && n < 200) begin @(negedge clk); n++; end
    req = 1'b0;
    @(negedge clk);
    chk(mem[11'h2AA] == 8'hC3, "R6 second write stored", mem[11'h2AA], 8'hC3);
  endtask

  task automatic t_pf_abort;
    int n = 0; int hold = 0; bit bad = 0;
    t_write(11'h077, 8'h5A);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 11'h077; wdata = 8'hA5;
    while (we_n && n < 50) begin @(negedge clk); n++; end
    pf = 1'b1;
    @(negedge clk);
    chk(we_n && ce_n && !dq_oe, "R8 abort releases strobes and bus", {we_n, ce_n, dq_oe}, 6);
    chk(ack && err, "R8 abort acknowledged with error", {ack, err}, 3);
    req = 1'b0;
    @(negedge clk);
    // Read request held while power-fail is high: must not start.
    req = 1'b1; wr = 1'b0; addr = 11'h077;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!ce_n || !we_n || dq_oe || ack) bad = 1;
    end
    chk(!bad, "R9 no access while power-fail", bad, 0);
    pf = 1'b0;
    n = 0;
    while (ce_n && n < 100) begin @(negedge clk); hold++; n++; end
    chk(hold >= PFH, "R9 lockout after power-fail", hold, PFH);
    while (!ack && n < 200) begin @(negedge clk); n++; end
    req = 1'b0;
    chk(rdata == 8'h5A && !err, "R8 aborted byte unchanged", rdata, 8'h5A);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 7 + 3);
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_write(11'h000, 8'hA5);
    t_read(11'h000, 8'hA5);
    t_write(11'h7FF, 8'h5A);
    t_read(11'h7FF, 8'h5A);
    t_write(11'h123, 8'hFF);
    t_write(11'h124, 8'h00);
    t_read(11'h123, 8'hFF);
    t_read(11'h124, 8'h00);
    t_read(11'h400, DW'(11'h400 * 7 + 3));
    t_recovery();
    t_pf_abort();
    t_read(11'h155, 8'h3C);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule